// File: doc/BRIEF.md
# Descriptor-Chained Frame Fetcher

This block feeds a display pipeline with framebuffer words. It reads a chain of
four-word descriptors from memory. Each descriptor gives the address of the next
descriptor, the start address of the frame data, a frame tag and a command word.
It then copies the number of 32-bit words given in the command word into a pixel
FIFO. The copy uses bursts of a fixed size. When the copy is done, the block moves
on to the next descriptor. If a descriptor points to itself, the same frame is
shown again on every refresh without software doing anything.

Software starts the engine by writing the address of a descriptor into the
pointer register. The engine then runs without stopping. If software writes the
pointer while a frame is being copied, the new address is only used at the next
frame boundary, so a frame is never cut short. The command word can ask for two
sticky interrupt flags, one at the start of a frame and one at the end. It can
also mark the frame as a palette load. The copies of the source address, the tag
and the command that were last loaded can be read on status outputs.

Top module: `fdma_fetch`

## Requirements
- R1: After reset, `mem_req`, `fifo_push`, `irq_sof`, `irq_eof`, `cur_src`, `cur_id` and `cur_cmd` are all zero. The engine makes no memory request until the pointer is written.
- R2: A descriptor is fetched as one memory request with `mem_len` = 4 at the descriptor address. The four words that come back are used in this order: next pointer, source address, frame tag, command. After the load, `cur_src`, `cur_id` and `cur_cmd` hold the source address, tag and command of that descriptor.
- R3: A frame pushes exactly `cmd[LEN_W-1:0]` words into the FIFO. The words are read in order from consecutive word addresses (step 4) that start at the source address.
- R4: Each data request asks for min(B, words remaining in the frame) words. B is 4, 8, 16 or 16 for `burst_sel` values 0, 1, 2 and 3.
- R5: A data request is raised only when `fifo_free` is at least its length. The FIFO therefore never receives a word while it is full.
- R6: After a frame ends, the next descriptor is fetched from that frame's next-pointer word. A descriptor whose next pointer is its own address repeats without end.
- R7: If command bit 31 is set, `irq_sof` rises once the descriptor is loaded, before the first word of that frame is pushed.
- R8: If command bit 30 is set, `irq_eof` rises in the cycle after the last word of the frame is pushed. If bit 30 is clear, `irq_eof` does not rise.
- R9: `fifo_pal` equals command bit 28 of the current frame on every push.
- R10: A pointer write made while a frame is being copied does not shorten that frame. The written address replaces the next pointer at the following frame boundary only.
- R11: A frame whose length field is 0 makes no data request. Its end flag (bit 30) is raised at once, and the next descriptor is fetched straight away.
- R12: A 1 on `irq_clr[0]` clears `irq_sof`, and a 1 on `irq_clr[1]` clears `irq_eof`. Each flag holds its value until it is cleared. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_wr | input | 1 | Write strobe for the descriptor pointer |
| ptr_wdata | input | AW | Descriptor address to write |
| burst_sel | input | 2 | Burst size code: 0 = 4 words, 1 = 8, 2 or 3 = 16 |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | AW | Byte address of the request |
| mem_len | output | 5 | Number of words requested |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data word valid |
| mem_rdata | input | 32 | Read data word |
| fifo_free | input | FREE_W | Free entries in the pixel FIFO |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_data | output | 32 | Word pushed |
| fifo_pal | output | 1 | The pushed word belongs to a palette load |
| cur_src | output | AW | Source address of the loaded descriptor |
| cur_id | output | 32 | Frame tag of the loaded descriptor |
| cur_cmd | output | 32 | Command word of the loaded descriptor |
| irq_clr | input | 2 | Clear for the flags: bit 0 = start flag, bit 1 = end flag |
| irq_sof | output | 1 | Sticky start-of-frame flag |
| irq_eof | output | 1 | Sticky end-of-frame flag |

## Verification
The hardest case to reach is a pointer write that arrives in the middle of a long self-linked frame, at a moment when the FIFO is nearly full. The engine must stall on FIFO room, finish the old frame and only then jump to the new chain. The bench drains its FIFO model at one third of the fill rate, so bursts often wait for room. It writes the pointer just after the fifth word of a 40-word self-linked frame, and changes the burst size between frames. The new chain ends with a zero-length frame followed by a self-linked one, which checks both the immediate end flag and the repeat.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam int BLEN_W     = 5;   // holds a burst length of up to 16 words
    localparam int DESC_WORDS = 4;

    localparam int CMD_SOF_BIT = 31;
    localparam int CMD_EOF_BIT = 30;
    localparam int CMD_PAL_BIT = 28;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DREQ  = 3'd1,
        ST_DRSP  = 3'd2,
        ST_BREQ  = 3'd3,
        ST_BDATA = 3'd4
    } fdma_state_e;

    // Burst size code -> words per burst
    function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] code);
        case (code)
            2'd0:    burst_words = BLEN_W'(4);
            2'd1:    burst_words = BLEN_W'(8);
            default: burst_words = BLEN_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/fdma_burst_sizer.sv
module fdma_burst_sizer
    import fdma_pkg::*;
#(
    parameter int LEN_W  = 24,
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        burst_sel,
    input  logic [LEN_W-1:0]  remain,
    input  logic [FREE_W-1:0] fifo_free,
    output logic [BLEN_W-1:0] blen,
    output logic              room_ok
);
    logic [BLEN_W-1:0] full_len;

    always_comb begin
        full_len = burst_words(burst_sel);
        if (remain < LEN_W'(full_len)) begin
            blen = remain[BLEN_W-1:0];
        end else begin
            blen = full_len;
        end
        room_ok = (fifo_free >= FREE_W'(blen));
    end

    // R4: a burst is never empty while words remain, and never overruns the frame
    p_blen_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0) |-> (blen != '0 && LEN_W'(blen) <= remain));

    // R4: a burst never exceeds the selected size
    p_blen_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blen <= burst_words(burst_sel));

endmodule

// File: rtl/fdma_irq_flags.sv
module fdma_irq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_sof,
    input  logic       set_eof,
    input  logic [1:0] clr,
    output logic       irq_sof,
    output logic       irq_eof
);
    typedef struct packed {
        logic sof;
        logic eof;
    } flags_t;

    flags_t q, n;

    always_comb begin
        n = q;
        if (clr[0]) n.sof = 1'b0;
        if (clr[1]) n.eof = 1'b0;
        if (set_sof) n.sof = 1'b1;   // set wins over clear
        if (set_eof) n.eof = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign irq_sof = q.sof;
    assign irq_eof = q.eof;

    // R12: a clear with no set empties the flag
    p_clr_sof_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !set_sof) |=> !irq_sof);

    // R12: a flag stays set until cleared
    p_keep_eof_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eof && !clr[1]) |=> irq_eof);

endmodule

// File: rtl/fdma_seq.sv
module fdma_seq
    import fdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [AW-1:0]     ptr_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [BLEN_W-1:0] blen,
    input  logic              room_ok,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [BLEN_W-1:0] mem_len,
    output logic [LEN_W-1:0]  remain,
    output logic              fifo_push,
    output logic [31:0]       fifo_data,
    output logic              fifo_pal,
    output logic [AW-1:0]     cur_src,
    output logic [31:0]       cur_id,
    output logic [31:0]       cur_cmd,
    output logic              set_sof,
    output logic              set_eof
);
    typedef struct packed {
        fdma_state_e       st;
        logic [AW-1:0]     desc_addr;
        logic [AW-1:0]     rd_addr;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     hold_src;
        logic [AW-1:0]     src;
        logic [AW-1:0]     pend_addr;
        logic              pend_vld;
        logic [1:0]        widx;
        logic [31:0]       hold_id;
        logic [31:0]       id;
        logic [31:0]       cmd;
        logic [LEN_W-1:0]  rem;
        logic [BLEN_W-1:0] beats;
    } seq_t;

    seq_t q, n;
    logic boundary;

    always_comb begin
        n         = q;
        boundary  = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = q.desc_addr;
        mem_len   = BLEN_W'(DESC_WORDS);
        fifo_push = 1'b0;
        set_sof   = 1'b0;
        set_eof   = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (ptr_wr) begin
                    n.desc_addr = ptr_wdata;
                    n.st        = ST_DREQ;
                end
            end
            ST_DREQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    n.st   = ST_DRSP;
                    n.widx = 2'd0;
                end
            end
            ST_DRSP: begin
                if (mem_rvalid) begin
                    n.widx = q.widx + 2'd1;
                    case (q.widx)
                        2'd0: n.nxt      = mem_rdata[AW-1:0];
                        2'd1: n.hold_src = mem_rdata[AW-1:0];
                        2'd2: n.hold_id  = mem_rdata;
                        default: begin
                            n.src     = q.hold_src;
                            n.id      = q.hold_id;
                            n.cmd     = mem_rdata;
                            n.rem     = mem_rdata[LEN_W-1:0];
                            n.rd_addr = q.hold_src;
                            set_sof   = mem_rdata[CMD_SOF_BIT];
                            if (mem_rdata[LEN_W-1:0] == '0) begin
                                set_eof  = mem_rdata[CMD_EOF_BIT];
                                boundary = 1'b1;
                            end else begin
                                n.st = ST_BREQ;
                            end
                        end
                    endcase
                end
            end
            ST_BREQ: begin
                mem_addr = q.rd_addr;
                mem_len  = blen;
                if (room_ok) begin
                    mem_req = 1'b1;
                    if (mem_gnt) begin
                        n.beats = blen;
                        n.st    = ST_BDATA;
                    end
                end
            end
            ST_BDATA: begin
                mem_addr = q.rd_addr;
                mem_len  = q.beats;
                if (mem_rvalid) begin
                    fifo_push = 1'b1;
                    n.rem     = q.rem - LEN_W'(1);
                    n.rd_addr = q.rd_addr + AW'(4);
                    n.beats   = q.beats - BLEN_W'(1);
                    if (q.beats == BLEN_W'(1)) begin
                        if (q.rem == LEN_W'(1)) begin
                            set_eof  = q.cmd[CMD_EOF_BIT];
                            boundary = 1'b1;
                        end else begin
                            n.st = ST_BREQ;
                        end
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        // Frame boundary: take the pending pointer if any, else the chain link
        if (boundary) begin
            n.st        = ST_DREQ;
            n.desc_addr = q.pend_vld ? q.pend_addr : q.nxt;
            n.pend_vld  = 1'b0;
        end

        // A write while running waits for the following boundary
        if (ptr_wr && q.st != ST_IDLE) begin
            n.pend_vld  = 1'b1;
            n.pend_addr = ptr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign remain    = q.rem;
    assign fifo_data = mem_rdata;
    assign fifo_pal  = q.cmd[CMD_PAL_BIT];
    assign cur_src   = q.src;
    assign cur_id    = q.id;
    assign cur_cmd   = q.cmd;

    // R3: no word is pushed beyond the programmed length
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (q.rem != '0));

    // R10: the chain position is frozen while waiting to issue a burst
    p_desc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BREQ) |=> $stable(q.desc_addr));

endmodule

// File: rtl/fdma_fetch.sv
module fdma_fetch
    import fdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_W  = 24,
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [AW-1:0]     ptr_wdata,
    input  logic [1:0]        burst_sel,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [BLEN_W-1:0] mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_push,
    output logic [31:0]       fifo_data,
    output logic              fifo_pal,
    output logic [AW-1:0]     cur_src,
    output logic [31:0]       cur_id,
    output logic [31:0]       cur_cmd,
    input  logic [1:0]        irq_clr,
    output logic              irq_sof,
    output logic              irq_eof
);
    logic [BLEN_W-1:0] blen;
    logic              room_ok;
    logic [LEN_W-1:0]  remain;
    logic              set_sof;
    logic              set_eof;

    fdma_seq #(.AW(AW), .LEN_W(LEN_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (ptr_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .blen      (blen),
        .room_ok   (room_ok),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len),
        .remain    (remain),
        .fifo_push (fifo_push),
        .fifo_data (fifo_data),
        .fifo_pal  (fifo_pal),
        .cur_src   (cur_src),
        .cur_id    (cur_id),
        .cur_cmd   (cur_cmd),
        .set_sof   (set_sof),
        .set_eof   (set_eof)
    );

    fdma_burst_sizer #(.LEN_W(LEN_W), .FREE_W(FREE_W)) sizer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst_sel(burst_sel),
        .remain   (remain),
        .fifo_free(fifo_free),
        .blen     (blen),
        .room_ok  (room_ok)
    );

    fdma_irq_flags flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_sof(set_sof),
        .set_eof(set_eof),
        .clr    (irq_clr),
        .irq_sof(irq_sof),
        .irq_eof(irq_eof)
    );

    // R6: a request that is waiting keeps its address
    p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr));

endmodule

// File: tb/fdma_fetch_tb_top.sv
`timescale 1ns/1ps
module fdma_fetch_tb_top;
    localparam int DEPTH  = 20;
    localparam int LEN_W  = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic [1:0]  burst_sel = 2'd1;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  fifo_free = 8'(DEPTH);
    logic        fifo_push;
    logic [31:0] fifo_data;
    logic        fifo_pal;
    logic [31:0] cur_src, cur_id, cur_cmd;
    logic [1:0]  irq_clr = 2'b00;
    logic        irq_sof, irq_eof;

    always #2.5 clk = ~clk;

    fdma_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .burst_sel(burst_sel), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .fifo_free(fifo_free), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .fifo_pal(fifo_pal), .cur_src(cur_src),
        .cur_id(cur_id), .cur_cmd(cur_cmd), .irq_clr(irq_clr),
        .irq_sof(irq_sof), .irq_eof(irq_eof)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Memory contents: descriptors stored, data computed from the address
    int unsigned dmem[int unsigned];
    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        return pat(a);
    endfunction
    function automatic int bl(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 16;
    endfunction

    // Reference model state
    logic [31:0] rq[$];
    int          lat = 0;
    int          fcnt = 0;
    int          cyc = 0;
    bit          push_seen = 0;
    bit          have_frame = 0;
    logic [31:0] f_addr = '0, f_next = '0, f_src = '0, f_id = '0, f_cmd = '0;
    int          f_len = 0, f_pushed = 0, f_req = 0, desc_rx = 4;
    bit          f_sof_seen = 0, f_eof_seen = 0;
    bit          pend = 0;
    logic [31:0] pend_addr = '0;
    int          frames_done = 0;
    bit          prev_sof = 0, prev_eof = 0;
    bit          sof_clr_req = 0, eof_clr_req = 0;
    int          sof_chk = 0, eof_chk = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R12: cleared flags read zero two samples after the rise
                if (sof_chk > 0) begin
                    sof_chk--;
                    if (sof_chk == 0) chk(irq_sof == 1'b0, "R12", "start flag clear", 32'(irq_sof), 0);
                end
                if (eof_chk > 0) begin
                    eof_chk--;
                    if (eof_chk == 0) chk(irq_eof == 1'b0, "R12", "end flag clear", 32'(irq_eof), 0);
                end
                if (irq_sof && !prev_sof) begin
                    chk(have_frame && f_cmd[31] && desc_rx == 4 && f_pushed == 0 && !f_sof_seen,
                        "R7", "start flag rise", 32'(f_pushed), 0);
                    f_sof_seen = 1; sof_clr_req = 1; sof_chk = 2;
                end
                if (irq_eof && !prev_eof) begin
                    chk(have_frame && f_cmd[30] && desc_rx == 4 && f_pushed == f_len && !f_eof_seen,
                        "R8", "end flag rise", 32'(f_pushed), 32'(f_len));
                    f_eof_seen = 1; eof_clr_req = 1; eof_chk = 2;
                end
                prev_sof = irq_sof; prev_eof = irq_eof;

                if (ptr_wr) begin pend = 1; pend_addr = ptr_wdata; end

                if (mem_rvalid) begin
                    void'(rq.pop_front());
                    if (desc_rx < 4) desc_rx++;
                end

                push_seen = fifo_push;
                if (fifo_push) begin
                    chk(fcnt < DEPTH, "R5", "push into full fifo", 32'(fcnt), DEPTH - 1);
                    chk(f_pushed < f_len, "R3", "push beyond length", 32'(f_pushed), 32'(f_len));
                    chk(fifo_data == pat(f_src + 32'(4 * f_pushed)), "R3", "pushed word",
                        fifo_data, pat(f_src + 32'(4 * f_pushed)));
                    chk(fifo_pal == f_cmd[28], "R9", "palette mark", 32'(fifo_pal), 32'(f_cmd[28]));
                    f_pushed++;
                end

                if (mem_req && mem_gnt) begin
                    if (!have_frame || (desc_rx == 4 && f_pushed == f_len && f_req == f_len)) begin
                        logic [31:0] ea;
                        ea = pend ? pend_addr : f_next;
                        chk(have_frame || pend, "R1", "request before pointer write", mem_addr, 0);
                        chk(mem_len == 5'd4, "R2", "descriptor request length", 32'(mem_len), 4);
                        chk(mem_addr == ea, pend ? "R10" : "R6", "descriptor address", mem_addr, ea);
                        if (have_frame) begin
                            chk(cur_src == f_src, "R2", "status source", cur_src, f_src);
                            chk(cur_id == f_id, "R2", "status tag", cur_id, f_id);
                            chk(cur_cmd == f_cmd, "R2", "status command", cur_cmd, f_cmd);
                            chk(f_sof_seen == f_cmd[31], "R7", "start flag per frame", 32'(f_sof_seen), 32'(f_cmd[31]));
                            chk(f_eof_seen == f_cmd[30], f_len == 0 ? "R11" : "R8", "end flag per frame",
                                32'(f_eof_seen), 32'(f_cmd[30]));
                            frames_done++;
                        end
                        pend = 0;
                        have_frame = 1;
                        f_addr = mem_addr;
                        f_next = rd_word(mem_addr);
                        f_src  = rd_word(mem_addr + 4);
                        f_id   = rd_word(mem_addr + 8);
                        f_cmd  = rd_word(mem_addr + 12);
                        f_len  = int'(f_cmd[LEN_W-1:0]);
                        f_pushed = 0; f_req = 0; desc_rx = 0;
                        f_sof_seen = 0; f_eof_seen = 0;
                    end else begin
                        int rem_w, el;
                        rem_w = f_len - f_req;
                        el = (rem_w < bl(burst_sel)) ? rem_w : bl(burst_sel);
                        chk(f_len != 0, "R11", "data request on empty frame", 32'(mem_len), 0);
                        chk(mem_addr == f_src + 32'(4 * f_req), "R3", "burst address",
                            mem_addr, f_src + 32'(4 * f_req));
                        chk(int'(mem_len) == el, "R4", "burst length", 32'(mem_len), 32'(el));
                        chk(int'(fifo_free) >= int'(mem_len), "R5", "room at request",
                            32'(fifo_free), 32'(mem_len));
                        f_req += int'(mem_len);
                    end
                    for (int i = 0; i < int'(mem_len); i++) rq.push_back(rd_word(mem_addr + 32'(4 * i)));
                    lat = 2;
                end
            end

            @(posedge clk);
            #1;
            cyc++;
            if (push_seen) fcnt++;
            push_seen = 0;
            if (fcnt > 0 && (cyc % 3) == 0) fcnt--;
            fifo_free  = 8'(DEPTH - fcnt);
            mem_gnt    = (rq.size() == 0) && ((cyc % 3) != 1);
            if (lat > 0) lat--;
            mem_rvalid = (rq.size() > 0) && (lat == 0) && ((cyc % 5) != 2);
            mem_rdata  = mem_rvalid ? rq[0] : 32'h0;
            irq_clr    = {eof_clr_req, sof_clr_req};
            sof_clr_req = 0; eof_clr_req = 0;
        end
    end

    task automatic write_ptr(input logic [31:0] a);
        @(posedge clk); #1;
        ptr_wr = 1'b1; ptr_wdata = a;
        @(posedge clk); #1;
        ptr_wr = 1'b0;
    endtask

    task automatic wait_frames(input int k);
        int target;
        target = frames_done + k;
        while (frames_done < target) @(posedge clk);
    endtask

    initial begin
        // Descriptors: D0 self-linked, then D1 -> D2 (empty) -> D3 self-linked
        dmem[32'h1000] = 32'h1000; dmem[32'h1004] = 32'h4000;
        dmem[32'h1008] = 32'h10;   dmem[32'h100C] = 32'hC000_0028;
        dmem[32'h1100] = 32'h1200; dmem[32'h1104] = 32'h5000;
        dmem[32'h1108] = 32'h11;   dmem[32'h110C] = 32'h1000_0025;
        dmem[32'h1200] = 32'h1300; dmem[32'h1204] = 32'h7000;
        dmem[32'h1208] = 32'h22;   dmem[32'h120C] = 32'h4000_0000;
        dmem[32'h1300] = 32'h1300; dmem[32'h1304] = 32'h6000;
        dmem[32'h1308] = 32'h33;   dmem[32'h130C] = 32'h8000_0010;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(mem_req == 1'b0, "R1", "req after reset", 32'(mem_req), 0);
        chk(fifo_push == 1'b0, "R1", "push after reset", 32'(fifo_push), 0);
        chk(irq_sof == 1'b0 && irq_eof == 1'b0, "R1", "flags after reset", {30'd0, irq_eof, irq_sof}, 0);
        chk(cur_src == 0 && cur_id == 0 && cur_cmd == 0, "R1", "status after reset", cur_cmd, 0);
        repeat (10) @(posedge clk);

        burst_sel = 2'd1;
        write_ptr(32'h1000);
        wait_frames(2);            // R6: self-link repeats
        burst_sel = 2'd0;
        wait_frames(1);
        burst_sel = 2'd2;
        wait_frames(1);
        burst_sel = 2'd3;
        wait_frames(1);
        // R10: pointer write in the middle of a frame
        while (!(f_addr == 32'h1000 && f_len == 40 && f_pushed == 5)) @(posedge clk);
        write_ptr(32'h1100);
        wait_frames(6);
        chk(f_addr == 32'h1300, "R6", "chain settled on self link", f_addr, 32'h1300);
        repeat (20) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog frames", 32'(frames_done), 0);
        finish_run();
    end

endmodule